// File: doc/BRIEF.md
# Tuning Window Tap Selector

After a sampling-clock tuning sweep, this block picks the tap position at which received data should be sampled. The sweep tries every one of N taps twice, in order, so probe `i` used tap `i mod N`. Two 2N-bit vectors arrive with the start strobe. One holds pass/fail per probe. The other holds the data-compare outcome per probe.

The block first folds the two copies of each tap together, so that a single bad probe disqualifies that tap in both halves of the sweep. It then walks the 2N merged entries one per clock. During the walk it tracks the longest run of passing probes and the longest run of compare matches. The chosen tap is the midpoint of the winning run, reduced modulo N. If every probe passed, the pass run carries no information, so the compare-match run is used instead. A pass run that is too short reports failure. The controller that issues the tuning commands loads the vectors, pulses start and waits for done.

Top module: `tap_window_select`

## Requirements
- R1: During and right after reset, `done`, `fail` and `tap_sel` are all 0.
- R2: Bit i of `pass_vec` (1 = pass) belongs to probe i on tap i mod N. Bits at index 2N and above are ignored. A 0 at either copy of a tap marks both copies of that tap as failed before the search.
- R3: When some merged probe failed, the selected tap is ((s + e) / 2) mod N, where s and e are the first and last indices of the longest run of consecutive merged passes. When runs tie, the run with the lowest index wins.
- R4: When some merged probe failed and the longest pass run is shorter than 3, `fail` is 1 and `tap_sel` is 0.
- R5: When all 2N merged probes pass, `fail` is 0. In `cmp_vec`, bit i = 0 means probe i matched. The compare vector is merged so that a 0 at either copy of a tap gives 0 at both copies. s and e are then taken from the longest run of merged zeros, with the lowest index winning ties, and the tap is ((s + e) / 2) mod N. If no zero exists, `tap_sel` is 0.
- R6: For a valid N, `done` is a one-cycle pulse. It is high in the cycle after the (2N+2)-th rising edge, counting the edge that samples `start` as the first. `tap_sel` and `fail` change only together with `done` and hold their values otherwise.
- R7: If N is 0, or if 2N does not fit below the vector width (2N ≥ VEC_W), `done` and `fail` rise after the edge that samples `start`, and `tap_sel` is 0.
- R8: A `start` that arrives while a search is running is ignored. The running search completes on its original inputs and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; vectors and N are sampled on this edge |
| tap_count | input | $clog2(VEC_W) | Number of taps N |
| pass_vec | input | VEC_W | Per-probe pass flags, 1 = pass |
| cmp_vec | input | VEC_W | Per-probe compare flags, 0 = data matched |
| tap_sel | output | $clog2(VEC_W)-1 | Selected tap |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Tuning failed; valid with and after done |

## Verification
The assertions assume that `tap_count` and the vectors are meaningful only on the edge where an idle block samples `start`. The bound checker therefore keeps its own copy of N and its own cycle counter, loaded at that edge. Input changes while a search runs must not matter. The bench enforces this by changing the inputs only between cases, apart from one deliberate start-while-busy case with different inputs. It draws N mostly from the valid range and occasionally from the invalid range. Its pass vectors are biased toward ones so that long runs, ties and the all-pass branch all occur.

// File: rtl/tap_window_select.sv
module tap_window_select #(
  parameter int VEC_W   = 32,  // power of two
  parameter int MIN_RUN = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(VEC_W)-1:0]   tap_count,
  input  logic [VEC_W-1:0]           pass_vec,
  input  logic [VEC_W-1:0]           cmp_vec,
  output logic [$clog2(VEC_W)-2:0]   tap_sel,
  output logic                       done,
  output logic                       fail
);
  localparam int IDX_W = $clog2(VEC_W);
  localparam int LW    = IDX_W + 1;
  localparam int TAP_W = IDX_W - 1;

  logic [LW-1:0]    two_n;
  logic             n_ok;
  logic [VEC_W-1:0] m_pass, m_cmp;

  assign two_n = {tap_count, 1'b0};
  assign n_ok  = (tap_count != '0) && (two_n < LW'(VEC_W));

  for (genvar j = 0; j < VEC_W; j++) begin : g_merge
    logic [IDX_W-1:0] lo, hi;
    logic             live;
    assign lo   = (IDX_W'(j) >= tap_count) ? IDX_W'(j) - tap_count : IDX_W'(j);
    assign hi   = lo + tap_count;
    assign live = LW'(j) < two_n;
    assign m_pass[j] = live && pass_vec[lo] && pass_vec[hi];
    assign m_cmp[j]  = live && cmp_vec[lo] && cmp_vec[hi];
  end

  logic             busy, fin;
  logic [IDX_W-1:0] idx, n_r;
  logic [VEC_W-1:0] mp, mc;
  logic [IDX_W-1:0] p_run, p_best, p_st, p_end;
  logic [IDX_W-1:0] c_run, c_best, c_st, c_end;

  logic             p_bit, c_bit, p_up, c_up, last;
  logic [IDX_W-1:0] p_len, c_len;

  assign p_bit = mp[idx];
  assign c_bit = ~mc[idx];
  assign p_len = p_run + 1'b1;
  assign c_len = c_run + 1'b1;
  assign p_up  = p_bit && (p_len > p_best);
  assign c_up  = c_bit && (c_len > c_best);
  assign last  = {1'b0, idx} == ({n_r, 1'b0} - LW'(1));

  logic             all_pass, ok;
  logic [IDX_W-1:0] s_sel, e_sel, half, wrapped;
  logic [TAP_W-1:0] sel_tap;

  assign all_pass = {1'b0, p_best} == {n_r, 1'b0};
  assign ok       = all_pass || (p_best >= IDX_W'(MIN_RUN));
  assign s_sel    = all_pass ? c_st  : p_st;
  assign e_sel    = all_pass ? c_end : p_end;
  assign half     = IDX_W'((LW'(s_sel) + LW'(e_sel)) >> 1);
  assign wrapped  = (half >= n_r) ? half - n_r : half;
  assign sel_tap  = ok ? TAP_W'(wrapped) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;  fin <= 1'b0;  idx <= '0;  n_r <= '0;
      mp <= '0;  mc <= '0;
      p_run <= '0;  p_best <= '0;  p_st <= '0;  p_end <= '0;
      c_run <= '0;  c_best <= '0;  c_st <= '0;  c_end <= '0;
      tap_sel <= '0;  done <= 1'b0;  fail <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (n_ok) begin
            busy <= 1'b1;  fin <= 1'b0;  idx <= '0;  n_r <= tap_count;
            mp <= m_pass;  mc <= m_cmp;
            p_run <= '0;  p_best <= '0;  p_st <= '0;  p_end <= '0;
            c_run <= '0;  c_best <= '0;  c_st <= '0;  c_end <= '0;
          end else begin
            done <= 1'b1;  fail <= 1'b1;  tap_sel <= '0;
          end
        end
      end else if (!fin) begin
        p_run <= p_bit ? p_len : '0;
        c_run <= c_bit ? c_len : '0;
        if (p_up) begin
          p_best <= p_len;  p_st <= idx - p_run;  p_end <= idx;
        end
        if (c_up) begin
          c_best <= c_len;  c_st <= idx - c_run;  c_end <= idx;
        end
        if (last) fin <= 1'b1;
        else      idx <= idx + 1'b1;
      end else begin
        busy <= 1'b0;  fin <= 1'b0;
        done <= 1'b1;  fail <= ~ok;  tap_sel <= sel_tap;
      end
    end
  end
endmodule

// File: rtl/tap_window_select_chk.sv
module tap_window_select_chk #(
  parameter int VEC_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic [$clog2(VEC_W)-1:0] tap_count,
  input logic                     busy,
  input logic [$clog2(VEC_W)-2:0] tap_sel,
  input logic                     done,
  input logic                     fail
);
  localparam int IDX_W = $clog2(VEC_W);
  localparam int LW    = IDX_W + 1;

  logic             good_n, accept;
  logic [LW-1:0]    cnt;
  logic [IDX_W-1:0] n_seen;

  assign good_n = (tap_count != '0) && ({tap_count, 1'b0} < LW'(VEC_W));
  assign accept = start && !busy && good_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;  n_seen <= '0;
    end else if (accept) begin
      cnt <= {tap_count, 1'b0} + LW'(1);  n_seen <= tap_count;
    end else if (cnt != '0) begin
      cnt <= cnt - LW'(1);
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);
  assert_done_due_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == LW'(1) |=> done);
  assert_done_not_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt == '0);
  assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(tap_sel) && $stable(fail));
  assert_tap_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail && !$past(start && !busy && !good_n) |-> IDX_W'(tap_sel) < n_seen);
  assert_fail_tap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && fail |-> tap_sel == '0);
  assert_bad_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !good_n |=> done && fail);
endmodule

bind tap_window_select tap_window_select_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tap_count(tap_count),
  .busy(busy), .tap_sel(tap_sel), .done(done), .fail(fail)
);

// File: tb/test_tap_window_select.sv
module test_tap_window_select;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  tap_count = '0;
  logic [31:0] pass_vec = '0;
  logic [31:0] cmp_vec = '0;
  logic [3:0]  tap_sel;
  logic        done, fail;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_window_select i_tap_window_select (
    .clk(clk), .rst_n(rst_n), .start(start), .tap_count(tap_count),
    .pass_vec(pass_vec), .cmp_vec(cmp_vec),
    .tap_sel(tap_sel), .done(done), .fail(fail)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void longest(input logic [31:0] v, input int len, input bit want,
                                  output int best, output int st, output int en);
    int run = 0;
    best = 0; st = 0; en = 0;
    for (int i = 0; i <= len; i++) begin
      if (i < len && v[i] == want) run++;
      else begin
        if (run > best) begin best = run; st = i - run; en = i - 1; end
        run = 0;
      end
    end
  endfunction

  function automatic void model(input int n, input logic [31:0] p, input logic [31:0] c,
                                output int tap, output bit f);
    logic [31:0] mp = '0, mc = '0;
    int best, st, en, cb, cs, ce;
    for (int j = 0; j < 2*n; j++) begin
      mp[j] = p[j % n] & p[(j % n) + n];
      mc[j] = c[j % n] & c[(j % n) + n];
    end
    longest(mp, 2*n, 1'b1, best, st, en);
    f = 1'b0;
    if (best == 2*n) begin
      longest(mc, 2*n, 1'b0, cb, cs, ce);
      tap = ((cs + ce) / 2) % n;
    end else if (best >= 3) begin
      tap = ((st + en) / 2) % n;
    end else begin
      tap = 0; f = 1'b1;
    end
  endfunction

  task automatic run_case(input int n, input logic [31:0] p, input logic [31:0] c,
                          input string req);
    int exp_tap, exp_cyc, cyc;
    bit exp_f;
    string treq;
    if (n == 0 || 2*n >= 32) begin
      exp_tap = 0; exp_f = 1'b1; exp_cyc = 1; treq = "R7";
    end else begin
      model(n, p, c, exp_tap, exp_f); exp_cyc = 2*n + 2; treq = "R6";
    end
    tap_count = 5'(n); pass_vec = p; cmp_vec = c; start = 1'b1;
    @(posedge clk); cyc = 1;
    @(negedge clk); start = 1'b0;
    while (!done && cyc < 100) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
    check(cyc == exp_cyc, {treq, " done timing"}, cyc, exp_cyc);
    check(int'(tap_sel) == exp_tap, {req, " tap"}, int'(tap_sel), exp_tap);
    check(fail == exp_f, {req, " fail"}, int'(fail), int'(exp_f));
    @(posedge clk); @(negedge clk);
    check(!done, "R6 done pulse width", int'(done), 0);
    check(int'(tap_sel) == exp_tap, "R6 tap held", int'(tap_sel), exp_tap);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && !fail && tap_sel == '0, "R1 reset state", int'({done, fail, tap_sel}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !fail && tap_sel == '0, "R1 after reset", int'({done, fail, tap_sel}), 0);

    // R2: one bad copy of tap 1 kills bits 1 and 9 -> run 2..8 -> tap 5
    run_case(8, 32'h0000_FDFF, 32'hFFFF_FFFF, "R2");
    // R2: bits above 2N ignored, all pass -> compare path
    run_case(8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 R5");
    // R3: tie between two 4-runs keeps the first
    run_case(8, 32'h0000_0F0F & 32'h0000_FFFF | 32'h0000_0000, 32'h0, "R3");
    run_case(8, 32'h0000_7777, 32'h0, "R3 tie");
    // R4: longest run of 3 passes, run of 2 fails
    run_case(8, 32'h0000_0707, 32'h0, "R4 len3");
    run_case(8, 32'h0000_0303, 32'h0, "R4 len2");
    run_case(8, 32'h0, 32'h0, "R4 none");
    // R5: all pass, compare zeros on taps 2..4 -> merged zeros 2..4 and 10..12
    run_case(8, 32'h0000_FFFF, 32'h0000_FFE3, "R5");
    run_case(8, 32'h0000_FFFF, 32'h0, "R5 all match");
    run_case(1, 32'hFFFF_FFFF, 32'h0, "R5 n1");
    run_case(15, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R5 n15");
    // R7: invalid counts
    run_case(0, 32'hFFFF_FFFF, 32'h0, "R7 zero");
    run_case(16, 32'hFFFF_FFFF, 32'h0, "R7 sixteen");
    run_case(31, 32'hFFFF_FFFF, 32'h0, "R7 max");

    // R8: start while busy is ignored
    begin
      int exp_tap, cyc;
      bit exp_f;
      model(8, 32'h0000_FDFF, 32'h0, exp_tap, exp_f);
      tap_count = 5'd8; pass_vec = 32'h0000_FDFF; cmp_vec = 32'h0; start = 1'b1;
      @(posedge clk); cyc = 1;
      @(negedge clk); start = 1'b0;
      repeat (3) begin @(posedge clk); cyc++; @(negedge clk); end
      tap_count = 5'd4; pass_vec = 32'h0000_0011; cmp_vec = 32'hFFFF_FFFF; start = 1'b1;
      @(posedge clk); cyc++; @(negedge clk); start = 1'b0;
      while (!done && cyc < 100) begin @(posedge clk); cyc++; @(negedge clk); end
      check(cyc == 18, "R8 timing kept", cyc, 18);
      check(int'(tap_sel) == exp_tap, "R8 tap kept", int'(tap_sel), exp_tap);
      check(fail == exp_f, "R8 fail kept", int'(fail), int'(exp_f));
      @(posedge clk); @(negedge clk);
    end

    // random mix, fixed seed
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED_0042);
    end
    for (int k = 0; k < 400; k++) begin
      int n, sel;
      logic [31:0] p, c;
      sel = int'($urandom_range(0, 9));
      if (sel < 5) n = 8;
      else if (sel < 9) n = int'($urandom_range(1, 15));
      else n = int'($urandom_range(16, 31)) % 32;
      p = $urandom | $urandom;
      if (sel == 3 || sel == 6) p = p | $urandom | $urandom;
      if (sel == 2) p = 32'hFFFF_FFFF;
      c = $urandom & $urandom;
      if (sel == 4) c = ~c;
      run_case(n, p, c, "R3 R5 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule